// File: doc/BRIEF.md
# Dual-Port Double-Data-Rate Static Memory Model

This block is a synthesizable behavioural model of a synchronous static memory with one port that only reads and another that only writes. Both ports can be busy in the same clock cycle. They take their addresses from one shared address bus, which is time-shared between them on successive rising clock edges. One edge carries a read address and the next edge carries a write address.

Each data port moves two words per clock cycle, one on the rising edge and one on the falling edge. Every access is therefore a two-word burst on an even/odd word pair. With a read and a write in flight together, four words cross the boundary in each cycle: two go out and two come in.

Read data appears a fixed number of cycles after the read address. A valid flag marks the read data, and a read returns the data of a write to the same word pair that was placed just before it on the address bus. The block is meant to stand in for a fast external memory in system-level RTL, or to serve as a compact on-chip scratch store behind a controller that already speaks this slot protocol.

Top module: `dualport_ddr_sram`

## Requirements
- R1: While `rst_n` is low, `q_valid` is 0 and `q` is 0 in both clock phases. The first rising edge after `rst_n` goes high is a read slot.
- R2: Rising edges alternate strictly between read slots and write slots. `addr` is taken as the read address on a read-slot edge and as the write address on a write-slot edge.
- R3: A read starts only when `rd_n` is 0 on a read-slot edge. With `rd_n` at 1 the slot does nothing, and `q_valid` stays 0 in the cycle where that read's data would have appeared.
- R4: A write starts only when `wr_n` is 0 on a write-slot edge. With `wr_n` at 1 the slot does nothing, the data on `d` in the following cycle is ignored, and the stored words stay unchanged.
- R5: For an accepted write, the first data word is sampled from `d` on the rising edge after the write-address edge, and is stored in the even word of the pair. The second data word is sampled on the falling edge that follows, and is stored in the odd word.
- R6: For an accepted read, `q_valid` is 1 for exactly one cycle, beginning at the second rising edge after the read-address edge. During the high phase of that cycle, `q` shows the even word. During the low phase, `q` shows the odd word.
- R7: Bit 0 of `addr` is ignored. A burst always covers the word pair whose base is `addr` with bit 0 cleared.
- R8: A read returns the data of every write whose address edge came before the read-address edge. This includes a write to the same pair whose address edge is the one immediately before, even though that write's data arrives in the same cycle as the read address. A write whose address edge comes after the read-address edge is not seen.
- R9: A read and a write can both proceed in the same cycle. Within one cycle, read data is driven on `q` while write data is sampled from `d`, and neither disturbs the other.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Both edges move data; rising edges carry addresses |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Shared word address, read or write by slot |
| rd_n | input | 1 | Read select, active low, sampled on read-slot edges |
| wr_n | input | 1 | Write select, active low, sampled on write-slot edges |
| d | input | DATA_W | Write data, two words per cycle |
| q | output | DATA_W | Read data, even word in the high phase and odd word in the low phase |
| q_valid | output | 1 | High for the cycle that carries a read burst |

## Verification
The two functions that collide are the commit of a write pair into the array and the fetch of a read to the same pair. The write's address edge is immediately before the read's address edge, so both land on the same rising edge. The bench provokes this by writing a pair in one slot pair and reading that same pair, at both even and odd addresses, on the very next read slot. It also does this while a new write to the pair is issued in the same slot pair. A reference model that updates on every accepted write address judges the results. The read must show the freshly written words and not the older contents, and it must not show the later write.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;
   typedef enum logic {
      SLOT_RD = 1'b0,
      SLOT_WR = 1'b1
   } slot_e;

   function automatic slot_e next_slot(input slot_e s);
      return (s == SLOT_RD) ? SLOT_WR : SLOT_RD;
   endfunction
endpackage

// File: rtl/dps_slot_ctrl.sv
`timescale 1ns/1ps
module dps_slot_ctrl
   import dps_pkg::*;
#(
   parameter int ADDR_W = 6,
   localparam int BASE_W = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic              rd_take,
   output logic              wr_take,
   output logic              rd_v,
   output logic [BASE_W-1:0] rd_base,
   output logic              wr_v,
   output logic [BASE_W-1:0] wr_base
);
   slot_e slot;
   logic  unused_lsb;

   assign unused_lsb = addr[0];
   assign rd_take    = rst_n && (slot == SLOT_RD) && !rd_n;
   assign wr_take    = rst_n && (slot == SLOT_WR) && !wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot    <= SLOT_RD;
         rd_v    <= 1'b0;
         wr_v    <= 1'b0;
         rd_base <= '0;
         wr_base <= '0;
      end else begin
         slot <= next_slot(slot);
         rd_v <= rd_take;
         wr_v <= wr_take;
         if (rd_take) rd_base <= addr[ADDR_W-1:1];
         if (wr_take) wr_base <= addr[ADDR_W-1:1];
      end
   end
endmodule

// File: rtl/dps_wr_capture.sv
`timescale 1ns/1ps
module dps_wr_capture #(
   parameter int DATA_W = 16,
   parameter int BASE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_v,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [DATA_W-1:0] d,
   output logic              commit_en,
   output logic [BASE_W-1:0] commit_base,
   output logic [DATA_W-1:0] commit_w0,
   output logic [DATA_W-1:0] commit_w1
);
   // rising edge after the address edge: even word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_en   <= 1'b0;
         commit_base <= '0;
         commit_w0   <= '0;
      end else begin
         commit_en <= wr_v;
         if (wr_v) begin
            commit_base <= wr_base;
            commit_w0   <= d;
         end
      end
   end

   // following falling edge: odd word
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_w1 <= '0;
      end else if (commit_en) begin
         commit_w1 <= d;
      end
   end
endmodule

// File: rtl/dps_array.sv
`timescale 1ns/1ps
module dps_array #(
   parameter int DATA_W = 16,
   parameter int BASE_W = 5,
   localparam int PAIRS = 1 << BASE_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [BASE_W-1:0] wbase,
   input  logic [DATA_W-1:0] w0,
   input  logic [DATA_W-1:0] w1,
   input  logic              re,
   input  logic [BASE_W-1:0] rbase,
   output logic [DATA_W-1:0] r0,
   output logic [DATA_W-1:0] r1
);
   logic hit;
   assign hit = we && (wbase == rbase);

   for (genvar gb = 0; gb < 2; gb++) begin : g_bank
      logic [DATA_W-1:0] mem [PAIRS];
      logic [DATA_W-1:0] wdat;
      logic [DATA_W-1:0] rd_q;

      assign wdat = (gb == 0) ? w0 : w1;

      always_ff @(posedge clk) begin
         if (we) mem[wbase] <= wdat;
      end

      // a commit on the fetch edge is forwarded
      always_ff @(posedge clk) begin
         if (re) rd_q <= hit ? wdat : mem[rbase];
      end
   end

   assign r0 = g_bank[0].rd_q;
   assign r1 = g_bank[1].rd_q;
endmodule

// File: rtl/dps_rd_launch.sv
`timescale 1ns/1ps
module dps_rd_launch #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_v,
   input  logic [DATA_W-1:0] r0,
   input  logic [DATA_W-1:0] r1,
   output logic [DATA_W-1:0] q,
   output logic              q_valid
);
   logic              stage_v;
   logic [DATA_W-1:0] q_rise;
   logic [DATA_W-1:0] q_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_v <= 1'b0;
         q_valid <= 1'b0;
         q_rise  <= '0;
         q_fall  <= '0;
      end else begin
         stage_v <= fetch_v;
         q_valid <= stage_v;
         if (stage_v) begin
            q_rise <= r0;
            q_fall <= r1;
         end
      end
   end

   // high phase carries the even word, low phase the odd word
   assign q = clk ? q_rise : q_fall;
endmodule

// File: rtl/dualport_ddr_sram.sv
`timescale 1ns/1ps
module dualport_ddr_sram #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q,
   output logic              q_valid
);
   localparam int BASE_W = ADDR_W - 1;

   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 2..12");
   end

   logic              rd_take, wr_take;
   logic              rd_v, wr_v;
   logic [BASE_W-1:0] rd_base, wr_base;
   logic              commit_en;
   logic [BASE_W-1:0] commit_base;
   logic [DATA_W-1:0] commit_w0, commit_w1;
   logic [DATA_W-1:0] fetch_w0, fetch_w1;
   logic              rd_valid;

   dps_slot_ctrl #(.ADDR_W(ADDR_W)) i_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .rd_take (rd_take),
      .wr_take (wr_take),
      .rd_v    (rd_v),
      .rd_base (rd_base),
      .wr_v    (wr_v),
      .wr_base (wr_base)
   );

   dps_wr_capture #(.DATA_W(DATA_W), .BASE_W(BASE_W)) i_wcap (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_v        (wr_v),
      .wr_base     (wr_base),
      .d           (d),
      .commit_en   (commit_en),
      .commit_base (commit_base),
      .commit_w0   (commit_w0),
      .commit_w1   (commit_w1)
   );

   dps_array #(.DATA_W(DATA_W), .BASE_W(BASE_W)) i_array (
      .clk   (clk),
      .we    (commit_en),
      .wbase (commit_base),
      .w0    (commit_w0),
      .w1    (commit_w1),
      .re    (rd_v),
      .rbase (rd_base),
      .r0    (fetch_w0),
      .r1    (fetch_w1)
   );

   dps_rd_launch #(.DATA_W(DATA_W)) i_launch (
      .clk     (clk),
      .rst_n   (rst_n),
      .fetch_v (rd_v),
      .r0      (fetch_w0),
      .r1      (fetch_w1),
      .q       (q),
      .q_valid (rd_valid)
   );

   assign q_valid = rd_valid;
endmodule

// File: rtl/dps_sva.sv
`timescale 1ns/1ps
module dps_sva (
   input logic clk,
   input logic rst_n,
   input logic rd_take,
   input logic wr_take,
   input logic commit_en,
   input logic rd_valid
);
   // R6
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == $past(rd_take, 3));

   // R6
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R5
   commit_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en == $past(wr_take, 2));

   // R2
   slot_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_take && wr_take));

   // R2
   rd_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |=> !rd_take);

   // R2
   wr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |=> !wr_take);
endmodule

bind dualport_ddr_sram dps_sva i_dps_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_take   (rd_take),
   .wr_take   (wr_take),
   .commit_en (commit_en),
   .rd_valid  (rd_valid)
);

// File: tb/test_dualport_ddr_sram.sv
`timescale 1ns/1ps
module test_dualport_ddr_sram;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 6;
   localparam int NVEC   = 13;
   localparam int VW     = 2 + 2*ADDR_W + 2*DATA_W;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [ADDR_W-1:0] addr;
   logic              rd_n, wr_n;
   logic [DATA_W-1:0] d;
   logic [DATA_W-1:0] q;
   logic              q_valid;

   int total = 0;
   int fails = 0;

   logic [DATA_W-1:0] model [1 << ADDR_W];
   logic              exp_valid;
   logic [DATA_W-1:0] exp0, exp1;
   logic [DATA_W-1:0] pend0, pend1;

   // {rsel, raddr, wsel, waddr, wd0, wd1}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {1'b0, 6'd0,  1'b1, 6'd4,  16'h1111, 16'h2222},
      {1'b1, 6'd4,  1'b1, 6'd9,  16'h3333, 16'h4444},
      {1'b1, 6'd5,  1'b1, 6'd10, 16'hAAAA, 16'hBBBB},
      {1'b1, 6'd10, 1'b1, 6'd10, 16'hCCCC, 16'hDDDD},
      {1'b1, 6'd11, 1'b0, 6'd8,  16'hEEEE, 16'hEEEE},
      {1'b1, 6'd8,  1'b0, 6'd0,  16'h0000, 16'h0000},
      {1'b0, 6'd4,  1'b1, 6'd4,  16'h5555, 16'h6666},
      {1'b1, 6'd4,  1'b1, 6'd20, 16'h7777, 16'h8888},
      {1'b1, 6'd20, 1'b1, 6'd30, 16'h9999, 16'h0101},
      {1'b1, 6'd31, 1'b1, 6'd63, 16'hF0F0, 16'h0F0F},
      {1'b1, 6'd62, 1'b1, 6'd0,  16'h1234, 16'h5678},
      {1'b1, 6'd1,  1'b0, 6'd0,  16'h0000, 16'h0000},
      {1'b0, 6'd0,  1'b0, 6'd0,  16'h0000, 16'h0000}
   };

   dualport_ddr_sram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dualport_ddr_sram (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .d       (d),
      .q       (q),
      .q_valid (q_valid)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
      end
   endtask

   // One read slot then one write slot; entered just after a falling edge.
   task automatic do_pair(input logic rsel, input logic [ADDR_W-1:0] ra,
                          input logic wsel, input logic [ADDR_W-1:0] wa,
                          input logic [DATA_W-1:0] wd0, input logic [DATA_W-1:0] wd1,
                          input string req);
      logic [DATA_W-1:0] n0, n1;
      addr = ra; rd_n = ~rsel; wr_n = 1'b1; d = pend0;
      @(posedge clk); #1;
      chk({"R6/R3 valid ", req}, 32'(q_valid), 32'(exp_valid));
      if (exp_valid) chk({"R6/R5/R8/R9 even word ", req}, 32'(q), 32'(exp0));
      d = pend1;
      @(negedge clk); #1;
      if (exp_valid) chk({"R6/R5/R8/R9 odd word ", req}, 32'(q), 32'(exp1));
      // R7: bit 0 of the address is dropped
      n0 = model[{ra[ADDR_W-1:1], 1'b0}];
      n1 = model[{ra[ADDR_W-1:1], 1'b1}];
      addr = wa; wr_n = ~wsel; rd_n = 1'b1;
      @(posedge clk); #1;
      chk({"R6 single-cycle valid ", req}, 32'(q_valid), 32'd0);
      @(negedge clk); #1;
      if (wsel) begin
         model[{wa[ADDR_W-1:1], 1'b0}] = wd0;
         model[{wa[ADDR_W-1:1], 1'b1}] = wd1;
         pend0 = wd0; pend1 = wd1;
      end else begin
         // R4: data following a deselected write slot must be ignored
         pend0 = 16'hDEAD; pend1 = 16'hBEEF;
      end
      exp_valid = rsel; exp0 = n0; exp1 = n1;
   endtask

   initial begin
      #100000;
      fails++; total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      rst_n = 1'b0; addr = '0; rd_n = 1'b1; wr_n = 1'b1; d = '0;
      exp_valid = 1'b0; exp0 = '0; exp1 = '0; pend0 = 16'hDEAD; pend1 = 16'hBEEF;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state in both phases
      chk("R1 reset valid", 32'(q_valid), 32'd0);
      chk("R1 reset q low phase", 32'(q), 32'd0);
      @(posedge clk); #1;
      chk("R1 reset q high phase", 32'(q), 32'd0);
      @(negedge clk); #1;
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         do_pair(VEC[i][VW-1], VEC[i][VW-2 -: ADDR_W],
                 VEC[i][VW-2-ADDR_W], VEC[i][VW-3-ADDR_W -: ADDR_W],
                 VEC[i][2*DATA_W-1 -: DATA_W], VEC[i][DATA_W-1:0],
                 $sformatf("vec%0d", i));
      end

      // R1: reset while a read is in flight
      do_pair(1'b1, 6'd4, 1'b0, 6'd0, 16'h0, 16'h0, "pre-reset");
      rst_n = 1'b0;
      exp_valid = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      chk("R1 mid-run reset valid", 32'(q_valid), 32'd0);
      chk("R1 mid-run reset q", 32'(q), 32'd0);
      @(posedge clk); #1;
      chk("R1 mid-run reset q high phase", 32'(q), 32'd0);
      @(negedge clk); #1;
      rst_n = 1'b1;
      pend0 = 16'hDEAD; pend1 = 16'hBEEF;
      // R1 first edge after release must be a read slot
      do_pair(1'b1, 6'd9, 1'b0, 6'd0, 16'h0, 16'h0, "post-reset R1");
      // R9: read burst out while a write burst comes in
      do_pair(1'b1, 6'd62, 1'b1, 6'd40, 16'hA5A5, 16'h5A5A, "post-reset");
      do_pair(1'b1, 6'd41, 1'b0, 6'd0, 16'h0, 16'h0, "post-reset fwd");
      do_pair(1'b0, 6'd0, 1'b0, 6'd0, 16'h0, 16'h0, "drain");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule